// File: doc/BRIEF.md
# Input Event Poll Controller

This block is a peripheral on a processor bus that moves one bit per access. It claims a window of five consecutive bit addresses starting at a base address (0x8000 by default). A write to the base address starts a poll of an external event source. The bit that is written chooses how the poll ends. A 0 gives a poll that gives up after a fixed number of clock cycles. A 1 gives a poll that waits as long as it takes for an event to arrive.

The event source offers a 4-bit code under a valid/ready handshake. The controller raises its event-ready output only while a poll is waiting, and an event is consumed in a cycle where valid and ready are both high. Back-pressure applies in both directions. An event source holds its valid and code until ready is seen. The processor holds its write request, with address and data stable, for as long as the bus-ready output is low.

When the poll ends, the result replaces the bit at the base address: 1 if an event was taken, 0 if the poll timed out. The next four addresses return the latched event code, least significant bit first. Reads never stall. A chip-select output marks accesses that fall inside the window.

Top module: `evpoll_ctrl`

## Requirements
- R1: `bus_sel` is 1 exactly when `bus_addr` lies in BASE..BASE+4. When it is 0, `bus_rdata` is 0 and `bus_ready` is 1.
- R2: A write to BASE holds `bus_ready` low, starting in the cycle the request first appears, until the poll has finished. `evt_ready` is 1 only while a poll is waiting.
- R3: A poll started by writing 0 that takes no event ends after TIMEOUT waiting cycles, so `bus_ready` is low for TIMEOUT+1 cycles in total. Afterwards BASE reads 0.
- R4: An event taken in waiting cycle k (k counted from 1) ends the poll, and `bus_ready` rises in the next cycle, giving k+1 stall cycles. Afterwards BASE reads 1. An event in the final timeout cycle (k = TIMEOUT) counts as received.
- R5: A poll started by writing 1 never times out. It ends only when an event is taken.
- R6: The code of a taken event is readable at BASE+1+i as bit i (BASE+1 holds the LSB). It keeps its value through polls that time out, until the next event is taken.
- R7: Reads inside the window complete with `bus_ready` high in the same cycle. BASE returns the result of the last poll.
- R8: An event offered while no poll is waiting sees `evt_ready` low and changes neither the flag nor the code.
- R9: Writes to BASE+1..BASE+4 do not stall and change no stored bit.
- R10: After reset, the flag and the code read 0, and no poll is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Processor access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bit address |
| bus_wdata | input | 1 | Write bit (poll mode at BASE) |
| bus_ready | output | 1 | Access completes this cycle when high |
| bus_rdata | output | 1 | Read bit, 0 when not selected |
| bus_sel | output | 1 | Address is inside the window |
| evt_valid | input | 1 | Event source offers a code |
| evt_code | input | 4 | Offered event code |
| evt_ready | output | 1 | Controller accepts an event |

## Verification
Read data and chip select are combinational and are sampled in the same cycle the request is driven. The poll stall is measured by counting the cycles in which `bus_ready` is low, starting with the cycle the write first appears. The bench computes the expected count as k+1 for an event taken in waiting cycle k and TIMEOUT+1 for a timeout, and compares the two. The flag and code take effect on the clock edge that ends the poll, so they are read back only after the write has completed. A sweep covers both modes and event offsets from before the first waiting cycle to beyond the timeout.

// File: rtl/evpoll_pkg.sv
package evpoll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } poll_state_t;
endpackage

// File: rtl/evpoll_decode.sv
module evpoll_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h8000,
  parameter int SPAN = 5,
  localparam int OFF_W = $clog2(SPAN)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel,
  output logic              is_base,
  output logic [OFF_W-1:0]  offset
);
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff    = addr - BASE;
    sel     = (diff < ADDR_W'(SPAN));
    is_base = (diff == '0);
    offset  = diff[OFF_W-1:0];
  end
endmodule

// File: rtl/evpoll_fsm.sv
module evpoll_fsm
  import evpoll_pkg::*;
#(
  parameter int TIMEOUT = 1024,
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic mode_block,
  input  logic evt_valid,
  output logic evt_ready,
  output logic stall,
  output logic end_hit,
  output logic end_miss
);
  poll_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic mode_q;
  logic expire;

  always_comb begin
    evt_ready = (state_q == ST_WAIT);
    end_hit   = evt_ready && evt_valid;
    expire    = evt_ready && !mode_q && (cnt_q == CNT_W'(TIMEOUT - 1));
    end_miss  = expire && !end_hit;
    stall     = start_req && (state_q != ST_DONE);
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE: if (start_req) state_d = ST_WAIT;
      ST_WAIT: if (end_hit || end_miss) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_req) begin
        cnt_q  <= '0;
        mode_q <= mode_block;
      end else if (state_q == ST_WAIT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evpoll_status.sv
module evpoll_status #(
  parameter int CODE_W = 4,
  localparam int SPAN = CODE_W + 1,
  localparam int OFF_W = $clog2(SPAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_hit,
  input  logic              end_miss,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [OFF_W-1:0]  offset,
  output logic              flag_q,
  output logic [CODE_W-1:0] code_q,
  output logic              rd_bit
);
  logic [SPAN-1:0] view;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      code_q <= '0;
    end else if (end_hit) begin
      flag_q <= 1'b1;
      code_q <= evt_code;
    end else if (end_miss) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    view   = {code_q, flag_q};
    rd_bit = 1'b0;
    for (int i = 0; i < SPAN; i++) begin
      if (offset == OFF_W'(i)) rd_bit = view[i];
    end
  end
endmodule

// File: rtl/evpoll_ctrl.sv
module evpoll_ctrl #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h8000,
  parameter int CODE_W = 4,
  parameter int TIMEOUT = 1024,
  localparam int SPAN = CODE_W + 1,
  localparam int OFF_W = $clog2(SPAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wdata,
  output logic              bus_ready,
  output logic              bus_rdata,
  output logic              bus_sel,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  output logic              evt_ready
);
  logic             sel_w, base_w, start_w, stall_w, hit_w, miss_w, rd_w;
  logic [OFF_W-1:0] off_w;
  logic             flag_w;
  logic [CODE_W-1:0] code_w;

  evpoll_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .SPAN(SPAN)) u_dec (
    .addr(bus_addr), .sel(sel_w), .is_base(base_w), .offset(off_w)
  );

  assign start_w = bus_valid && bus_we && base_w;

  evpoll_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_w), .mode_block(bus_wdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .stall(stall_w),
    .end_hit(hit_w), .end_miss(miss_w)
  );

  evpoll_status #(.CODE_W(CODE_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .end_hit(hit_w), .end_miss(miss_w),
    .evt_code(evt_code), .offset(off_w), .flag_q(flag_w), .code_q(code_w),
    .rd_bit(rd_w)
  );

  assign bus_sel   = sel_w;
  assign bus_ready = !stall_w;
  assign bus_rdata = bus_valid && !bus_we && sel_w && rd_w;
endmodule

// File: rtl/evpoll_checker.sv
module evpoll_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic              bus_sel,
  input logic              bus_ready,
  input logic              bus_rdata,
  input logic              evt_valid,
  input logic [CODE_W-1:0] evt_code,
  input logic              evt_ready,
  input logic              flag_q,
  input logic [CODE_W-1:0] code_q
);
  AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (!bus_rdata && bus_ready)); // R1
  AST_WAIT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ready && bus_valid && bus_we && bus_sel) |-> !bus_ready); // R2
  AST_HIT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> (bus_ready && flag_q)); // R4
  AST_CODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> (code_q == $past(evt_code))); // R6
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && evt_ready) |=> $stable(code_q)); // R8
  AST_READ_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we) |-> bus_ready); // R7
endmodule

bind evpoll_ctrl evpoll_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_sel(bus_sel), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
  .evt_valid(evt_valid), .evt_code(evt_code), .evt_ready(evt_ready),
  .flag_q(flag_w), .code_q(code_w)
);

// File: tb/evpoll_ctrl_bench.sv
module evpoll_ctrl_bench;
  localparam int T = 12;
  localparam logic [15:0] BASE = 16'h8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_we = 1'b0, bus_wdata = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_ready, bus_rdata, bus_sel, evt_ready;
  logic evt_valid = 1'b0;
  logic [3:0] evt_code = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  evpoll_ctrl #(.TIMEOUT(T)) u_evpoll_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .bus_sel(bus_sel), .evt_valid(evt_valid),
    .evt_code(evt_code), .evt_ready(evt_ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic d, output logic s, output logic r);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata; s = bus_sel; r = bus_ready;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic b, output int stall);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = b;
    stall = 0;
    #1;
    while (!bus_ready) begin
      stall++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic poll(input logic mode, input int e, input logic [3:0] code, output int stall);
    int c;
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = BASE; bus_wdata = mode;
    evt_code = code;
    stall = 0;
    c = 0;
    evt_valid = (e >= 0 && c >= e);
    #1;
    while (!bus_ready) begin
      stall++;
      @(negedge clk);
      c++;
      evt_valid = (e >= 0 && c >= e);
      #1;
    end
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0; evt_valid = 1'b0;
  endtask

  task automatic check_state(input string req, input logic fl, input logic [3:0] cd);
    logic d, s, r;
    rd(BASE, d, s, r);
    check({req, " flag"}, int'(d), int'(fl));
    for (int i = 0; i < 4; i++) begin
      rd(BASE + 16'(1 + i), d, s, r);
      check({req, " code bit"}, int'(d), int'(cd[i]));
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic d, s, r;
    int st, exp_st;
    logic exp_flag;
    logic [3:0] exp_code;
    logic [3:0] cd;
    int offs[9];
    offs = '{-1, 0, 1, 2, 5, T - 1, T, T + 1, T + 4};

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10 reset state
    check("R10 evt_ready idle", int'(evt_ready), 0);
    check_state("R10", 1'b0, 4'h0);
    exp_flag = 1'b0; exp_code = 4'h0;

    // R1 window decode
    for (int k = 0; k < 8; k++) begin
      logic [15:0] a;
      a = BASE - 16'd1 + 16'(k);
      rd(a, d, s, r);
      check("R1 sel", int'(s), int'(k >= 1 && k <= 5));
      check("R7 read ready", int'(r), 1);
      if (!(k >= 1 && k <= 5)) check("R1 rdata outside", int'(d), 0);
    end

    // R2..R6 sweep over mode and event offset
    cd = 4'h1;
    for (int m = 0; m < 2; m++) begin
      foreach (offs[j]) begin
        int e;
        logic hit;
        e = offs[j];
        if (m == 1 && e < 0) continue;
        cd = cd + 4'd5;
        poll(m[0], e, cd, st);
        hit = (e >= 0) && (m == 1 || e <= T);
        if (hit) exp_st = ((e < 1) ? 1 : e) + 1;
        else exp_st = T + 1;
        if (m == 1) check("R5 blocking stall", st, exp_st);
        else if (hit) check("R4 hit stall", st, exp_st);
        else check("R3 timeout stall", st, exp_st);
        check("R2 evt_ready after poll", int'(evt_ready), 0);
        exp_flag = hit;
        if (hit) exp_code = cd;
        check_state(hit ? "R4 R6" : "R3 R6", exp_flag, exp_code);
      end
    end

    // R8 events while idle ignored
    @(negedge clk);
    evt_valid = 1'b1; evt_code = ~exp_code;
    #1;
    check("R8 evt_ready idle", int'(evt_ready), 0);
    repeat (4) @(negedge clk);
    evt_valid = 1'b0;
    check_state("R8", exp_flag, exp_code);

    // R9 writes to code bits ignored
    for (int i = 1; i <= 4; i++) begin
      wr(BASE + 16'(i), ~exp_code[i-1], st);
      check("R9 no stall", st, 0);
    end
    check_state("R9", exp_flag, exp_code);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule